// File: doc/BRIEF.md
# Named Split-Phase Barrier Unit

This unit lets a group of processors meet at named barriers without tying arrival and waiting together. Each processor has an arrive port and a wait port, each carrying a barrier ID. An arrival is recorded in one clock and never stalls the processor, so it can go on with independent work. Later it holds its wait request on the same ID until the unit releases it.

Every barrier ID has its own participant mask, its own per-processor arrival vector and its own phase (sense) bit. A barrier completes when the accepted arrivals cover its mask. On completion the arrival vector is cleared, the sense bit flips and a one-cycle completion pulse is broadcast to all processors, all in the same clock edge that releases the waiters. Several barriers can be in progress at once. Bad arrivals are flagged on a per-processor error output and otherwise have no effect. An arrival is bad if it is a repeat from the same processor in the same phase, comes from a processor outside the mask, or targets a barrier that is being reconfigured.

Top module: `split_barrier_unit`

## Requirements
- R1: Out of reset every barrier has an all-ones participant mask, an empty arrival vector and sense 0. All outputs are 0.
- R2: An arrival from a participant that has not yet arrived is accepted. `arr_err` for that processor is 0 on the next cycle, and the barrier does not complete unless this arrival covers its mask.
- R3: On the clock edge after the accepted arrivals cover the mask, `bar_done[b]` is 1 for exactly one cycle and `bar_sense[b]` is inverted. The arrival vector is empty again, so the mask must be covered again before the next completion.
- R4: Processor p holds `wait_valid[p]` with `wait_id` = b. While p has an arrival pending on b, `wait_ok[p]` stays 0. `wait_ok[p]` becomes 1 on the same edge that raises `bar_done[b]`.
- R5: A wait on a barrier where the processor has no pending arrival (because the barrier has already completed) gives `wait_ok[p]` = 1 on the next cycle.
- R6: A second arrival by the same processor on the same barrier before completion sets `arr_err[p]` on the next cycle and is ignored.
- R7: An arrival from a processor whose bit is 0 in the barrier's mask sets `arr_err[p]` on the next cycle and is ignored.
- R8: Barriers are independent. Arrivals on one ID never complete another ID.
- R9: A configuration write (`cfg_we`, `cfg_id`, `cfg_mask`; bit p of the mask is processor p) loads the mask and empties that barrier's arrival vector. Arrivals to that ID in the same cycle are rejected with `arr_err`.
- R10: Arrivals from several processors to one barrier in the same cycle combine. If together they cover the mask, the barrier completes on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write participant mask |
| cfg_id | input | ID_W | Barrier ID to configure |
| cfg_mask | input | N_PROC | New participant mask, bit p = processor p |
| arr_valid | input | N_PROC | Arrival request per processor |
| arr_id | input | N_PROC*ID_W | Barrier ID per processor, processor p at bits p*ID_W |
| wait_valid | input | N_PROC | Wait request per processor (held while stalled) |
| wait_id | input | N_PROC*ID_W | Barrier ID waited on, processor p at bits p*ID_W |
| wait_ok | output | N_PROC | Release for a held wait |
| arr_err | output | N_PROC | Rejected arrival, one cycle after it |
| bar_done | output | N_BAR | One-cycle completion broadcast per barrier |
| bar_sense | output | N_BAR | Current phase bit per barrier |

## Verification
A corrupt arrival vector shows within one cycle. A barrier completes one arrival early or late, which appears on `bar_done` and on the `bar_sense` toggle. A stuck bit makes later duplicate checks raise `arr_err` where none is due. A wrong mask or a missed clear appears as a non-member being accepted, or as a barrier that stays open after all its members arrive. A wrong wait lookup releases `wait_ok` before the completion pulse or holds it after. The bench sweeps every non-empty mask on every barrier, so each of these shows up at the arrival that exposes it.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
    // Classification of one processor's arrival at one barrier slot
    typedef enum logic [1:0] {
        REJ_NONE      = 2'd0,
        REJ_DUP       = 2'd1,
        REJ_NONMEMBER = 2'd2,
        REJ_CFG       = 2'd3
    } rej_e;
endpackage

// File: rtl/sbu_arr_dec.sv
module sbu_arr_dec #(
    parameter int N_PROC = 4,
    parameter int N_BAR  = 4,
    parameter int ID_W   = 2
) (
    input  logic [N_PROC-1:0]      arr_valid,
    input  logic [N_PROC*ID_W-1:0] arr_id,
    output logic [N_BAR*N_PROC-1:0] req_flat
);
    // req_flat[b*N_PROC + p] : processor p arrives at barrier b
    always_comb begin
        req_flat = '0;
        for (int p = 0; p < N_PROC; p++) begin
            for (int b = 0; b < N_BAR; b++) begin
                if (arr_valid[p] && (int'(arr_id[p*ID_W +: ID_W]) == b))
                    req_flat[b*N_PROC + p] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sbu_slot.sv
module sbu_slot
    import sbu_pkg::*;
#(
    parameter int N_PROC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PROC-1:0] req,
    input  logic              cfg_we,
    input  logic [N_PROC-1:0] cfg_mask,
    output logic [N_PROC-1:0] nxt_arr,
    output logic [N_PROC-1:0] rej,
    output logic              done,
    output logic              sense
);
    typedef struct packed {
        logic [N_PROC-1:0] arr;
        logic [N_PROC-1:0] mask;
        logic              sense;
        logic              done;
    } slot_t;

    slot_t             q, d;
    rej_e              cls [N_PROC];
    logic [N_PROC-1:0] acc_d;
    logic [N_PROC-1:0] merged_d;

    always_comb begin
        d     = q;
        d.done = 1'b0;
        acc_d = '0;
        rej   = '0;
        for (int p = 0; p < N_PROC; p++) begin
            if (!req[p])               cls[p] = REJ_NONE;
            else if (cfg_we)           cls[p] = REJ_CFG;
            else if (!q.mask[p])       cls[p] = REJ_NONMEMBER;
            else if (q.arr[p])         cls[p] = REJ_DUP;
            else begin
                cls[p]   = REJ_NONE;
                acc_d[p] = 1'b1;
            end
            rej[p] = (cls[p] != REJ_NONE);
        end
        merged_d = q.arr | acc_d;
        if (cfg_we) begin
            d.mask = cfg_mask;
            d.arr  = '0;
        end else if ((|acc_d) && ((merged_d & q.mask) == q.mask)) begin
            d.arr   = '0;
            d.sense = ~q.sense;
            d.done  = 1'b1;
        end else begin
            d.arr = merged_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.arr   <= '0;
            q.mask  <= '1;
            q.sense <= 1'b0;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign nxt_arr = d.arr;
    assign done    = q.done;
    assign sense   = q.sense;

    AST_CLEAR_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.arr == '0)); // R3
    AST_SENSE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.sense != $past(q.sense))); // R3
    AST_MEMBER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.arr & ~q.mask) == '0)); // R7
    AST_DONE_NEEDS_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> ($past(|req) && !$past(cfg_we))); // R10
endmodule

// File: rtl/sbu_wait_port.sv
module sbu_wait_port #(
    parameter int N_BAR = 4,
    parameter int ID_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wait_valid,
    input  logic [ID_W-1:0]  wait_id,
    input  logic [N_BAR-1:0] pend_col,
    output logic             wait_ok
);
    typedef struct packed {
        logic ok;
    } wp_t;

    wp_t q, d;

    always_comb begin
        d.ok = 1'b0;
        if (wait_valid && (int'(wait_id) < N_BAR))
            d.ok = ~pend_col[wait_id];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q.ok <= 1'b0;
        else        q    <= d;
    end

    assign wait_ok = q.ok;

    AST_OK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        q.ok |-> $past(wait_valid)); // R4
endmodule

// File: rtl/split_barrier_unit.sv
module split_barrier_unit #(
    parameter int N_PROC = 4,
    parameter int N_BAR  = 4,
    parameter int ID_W   = (N_BAR > 1) ? $clog2(N_BAR) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [ID_W-1:0]        cfg_id,
    input  logic [N_PROC-1:0]      cfg_mask,
    input  logic [N_PROC-1:0]      arr_valid,
    input  logic [N_PROC*ID_W-1:0] arr_id,
    input  logic [N_PROC-1:0]      wait_valid,
    input  logic [N_PROC*ID_W-1:0] wait_id,
    output logic [N_PROC-1:0]      wait_ok,
    output logic [N_PROC-1:0]      arr_err,
    output logic [N_BAR-1:0]       bar_done,
    output logic [N_BAR-1:0]       bar_sense
);
    localparam int REQ_W = N_BAR * N_PROC;

    typedef struct packed {
        logic [N_PROC-1:0] err;
    } top_t;

    logic [REQ_W-1:0]  req_flat;
    logic [REQ_W-1:0]  nxt_flat;
    logic [REQ_W-1:0]  rej_flat;
    top_t              q, d;

    sbu_arr_dec #(.N_PROC(N_PROC), .N_BAR(N_BAR), .ID_W(ID_W)) u_dec (
        .arr_valid (arr_valid),
        .arr_id    (arr_id),
        .req_flat  (req_flat)
    );

    for (genvar b = 0; b < N_BAR; b++) begin : g_slot
        sbu_slot #(.N_PROC(N_PROC)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (req_flat[b*N_PROC +: N_PROC]),
            .cfg_we   (cfg_we && (int'(cfg_id) == b)),
            .cfg_mask (cfg_mask),
            .nxt_arr  (nxt_flat[b*N_PROC +: N_PROC]),
            .rej      (rej_flat[b*N_PROC +: N_PROC]),
            .done     (bar_done[b]),
            .sense    (bar_sense[b])
        );
    end

    for (genvar p = 0; p < N_PROC; p++) begin : g_wait
        logic [N_BAR-1:0] pend_col;
        for (genvar b = 0; b < N_BAR; b++) begin : g_col
            assign pend_col[b] = nxt_flat[b*N_PROC + p];
        end
        sbu_wait_port #(.N_BAR(N_BAR), .ID_W(ID_W)) u_wp (
            .clk        (clk),
            .rst_n      (rst_n),
            .wait_valid (wait_valid[p]),
            .wait_id    (wait_id[p*ID_W +: ID_W]),
            .pend_col   (pend_col),
            .wait_ok    (wait_ok[p])
        );
    end

    always_comb begin
        d.err = '0;
        for (int b = 0; b < N_BAR; b++)
            d.err = d.err | rej_flat[b*N_PROC +: N_PROC];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q.err <= '0;
        else        q     <= d;
    end

    assign arr_err = q.err;

    AST_ERR_NEEDS_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.err & ~$past(arr_valid)) == '0)); // R6
endmodule

// File: tb/split_barrier_unit_tb.sv
`timescale 1ns/1ps
module split_barrier_unit_tb;
    localparam int NP = 4;
    localparam int NB = 4;
    localparam int IW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [IW-1:0]   cfg_id = '0;
    logic [NP-1:0]   cfg_mask = '0;
    logic [NP-1:0]   arr_valid = '0;
    logic [NP*IW-1:0] arr_id = '0;
    logic [NP-1:0]   wait_valid = '0;
    logic [NP*IW-1:0] wait_id = '0;
    logic [NP-1:0]   wait_ok;
    logic [NP-1:0]   arr_err;
    logic [NB-1:0]   bar_done;
    logic [NB-1:0]   bar_sense;

    int n_tests = 0;
    int n_fail  = 0;
    logic [NB-1:0] exp_sense = '0;

    always #4 clk = ~clk;

    split_barrier_unit #(.N_PROC(NP), .N_BAR(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_id(cfg_id),
        .cfg_mask(cfg_mask), .arr_valid(arr_valid), .arr_id(arr_id),
        .wait_valid(wait_valid), .wait_id(wait_id), .wait_ok(wait_ok),
        .arr_err(arr_err), .bar_done(bar_done), .bar_sense(bar_sense)
    );

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Inputs are set after a falling edge; go() crosses one rising edge
    // and returns at the next falling edge, where registered outputs are read.
    task automatic go();
        @(posedge clk);
        @(negedge clk);
        arr_valid = '0;
        cfg_we    = 1'b0;
    endtask

    task automatic arrive(int p, int b);
        arr_valid[p] = 1'b1;
        arr_id[p*IW +: IW] = IW'(b);
    endtask

    task automatic cfg(int b, int m);
        cfg_we   = 1'b1;
        cfg_id   = IW'(b);
        cfg_mask = NP'(m);
    endtask

    task automatic note_done(int b, bit expd);
        chk("R3 done pulse", int'(bar_done[b]), int'(expd));
        if (expd) exp_sense[b] = ~exp_sense[b];
        chk("R3 sense", int'(bar_sense[b]), int'(exp_sense[b]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=0 exp=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 wait_ok", int'(wait_ok), 0);
        chk("R1 arr_err", int'(arr_err), 0);
        chk("R1 bar_done", int'(bar_done), 0);
        chk("R1 bar_sense", int'(bar_sense), 0);
        // R1 default mask all ones: all four together complete barrier 2 (R10)
        for (int p = 0; p < NP; p++) arrive(p, 2);
        go();
        chk("R1 R10 err", int'(arr_err), 0);
        note_done(2, 1'b1);
        chk("R8 others idle", int'(bar_done & 4'b1011), 0);

        // Sweep every barrier and every non-empty mask
        for (int b = 0; b < NB; b++) begin
            for (int m = 1; m < (1 << NP); m++) begin
                int lo, hi, pc;
                lo = -1; hi = 0; pc = 0;
                for (int p = 0; p < NP; p++) if (m[p]) begin
                    if (lo < 0) lo = p;
                    hi = p; pc++;
                end
                cfg(b, m);
                go();
                chk("R9 cfg no done", int'(bar_done[b]), 0);
                arrive(lo, b);
                go();
                chk("R2 accept err", int'(arr_err[lo]), 0);
                note_done(b, pc == 1);
                if (pc >= 2) begin
                    arrive(lo, b);
                    go();
                    chk("R6 duplicate err", int'(arr_err[lo]), 1);
                    note_done(b, 1'b0);
                end
                for (int p = 0; p < NP; p++) begin
                    if (p == lo) continue;
                    arrive(p, b);
                    go();
                    if (m[p]) begin
                        chk("R2 member err", int'(arr_err[p]), 0);
                        note_done(b, p == hi);
                    end else begin
                        chk("R7 non-member err", int'(arr_err[p]), 1);
                        note_done(b, 1'b0);
                    end
                    chk("R8 other barriers", int'(bar_done & ~(NB'(1) << b)), 0);
                end
            end
        end

        // R4 / R5 wait behaviour on barrier 1 with mask 0011
        cfg(1, 3); go();
        arrive(0, 1); go();
        note_done(1, 1'b0);
        wait_valid[0] = 1'b1; wait_id[0 +: IW] = 2'd1;
        go();
        chk("R4 stalled", int'(wait_ok[0]), 0);
        go();
        chk("R4 still stalled", int'(wait_ok[0]), 0);
        arrive(1, 1); go();
        note_done(1, 1'b1);
        chk("R4 release with done", int'(wait_ok[0]), 1);
        wait_valid[0] = 1'b0;
        wait_valid[1] = 1'b1; wait_id[1*IW +: IW] = 2'd1;
        go();
        chk("R5 immediate release", int'(wait_ok[1]), 1);
        chk("R4 dropped wait", int'(wait_ok[0]), 0);
        wait_valid[1] = 1'b0;

        // R8 independent barriers 2 and 3, both mask 0011
        cfg(2, 3); go();
        cfg(3, 3); go();
        arrive(0, 2); arrive(1, 3); go();
        note_done(2, 1'b0);
        note_done(3, 1'b0);
        arrive(1, 2); go();
        note_done(2, 1'b1);
        chk("R8 barrier 3 held", int'(bar_done[3]), 0);
        arrive(0, 3); go();
        note_done(3, 1'b1);

        // R9 reconfigure clears pending arrivals and rejects same-cycle arrival
        arrive(0, 3); go();
        note_done(3, 1'b0);
        cfg(3, 3); arrive(1, 3); go();
        chk("R9 same-cycle arrival err", int'(arr_err[1]), 1);
        note_done(3, 1'b0);
        arrive(1, 3); go();
        chk("R9 pending cleared", int'(bar_done[3]), 0);
        arrive(0, 3); go();
        note_done(3, 1'b1);

        // R10 partial simultaneous group does not complete, full one does
        cfg(0, 15); go();
        arrive(0, 0); arrive(2, 0); go();
        note_done(0, 1'b0);
        arrive(1, 0); arrive(3, 0); go();
        chk("R10 group err", int'(arr_err), 0);
        note_done(0, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule